// File: doc/BRIEF.md
# Ordered Store Buffer with Forwarding and Barrier Marks

This block sits between a processor's load/store port and its data cache. A store to a line that the cache does not yet hold writable is taken into a small FIFO at once, and a read-for-ownership request for that line is raised in the same cycle. The processor keeps running. When ownership of a line is granted, every buffered entry on that line is flagged as owned. The oldest entry is written to the cache as soon as it is owned and the cache write port is ready, so entries leave strictly in program order.

Loads search the buffer by word address. The youngest matching entry supplies the data if its byte enables cover every requested byte. If a match exists but does not cover the request, the load is held until the entry drains. If nothing matches, the load goes to the cache. A store to an owned line can go straight to the cache and pass older unrelated entries. A store-ordering barrier stops that: it marks every entry present at that moment, and while any marked entry remains, later stores are queued behind them.

Control follows a three-state machine. In `SB_EMPTY` no entry is held. In `SB_OPEN` entries are held and none is marked. In `SB_FENCED` at least one marked entry remains. The transitions are:
- EMPTY→OPEN on an enqueue.
- OPEN→FENCED on an ordering barrier that finds entries present.
- OPEN→EMPTY and FENCED→EMPTY when the last entry drains.
- FENCED→OPEN when the last marked entry drains while unmarked ones remain.

Top module: `store_buffer`

## Requirements
- R1: A store with `st_owned` low is accepted without stall when the buffer is not full. In that same cycle `rinv_valid` is high and `rinv_line` equals the store's word address shifted right by `LINE_LG`.
- R2: A load whose word address matches buffered entries returns the data of the youngest match with `ld_fwd_hit` high, provided that entry's byte enables include every bit set in `ld_be`.
- R3: A load with no matching buffered word gives `ld_fwd_hit` low and `ld_stall` low, so it is served by the cache.
- R4: If the youngest matching entry lacks any requested byte, `ld_stall` is high and `ld_fwd_hit` low. This lasts until that entry has drained.
- R5: With `DEPTH` entries held, a store that cannot bypass raises `st_stall`. It adds no entry and raises no `rinv_valid`.
- R6: Entries are written to the cache in arrival order. An entry is written only once an `own_valid` grant naming its line has been seen. The head is presented on `cw_valid` and leaves on `cw_ready`.
- R7: A store with `st_owned` high goes directly to the cache port in the same cycle (`cw_valid` with its address and data, no entry kept) when four conditions hold: `cw_ready` is high, no marks are in effect, no buffered entry shares its line, and it passes older unowned entries on other lines.
- R8: A barrier with `bar_kind` 2'b10 (store ordering) or 2'b11 (full) marks every entry present. While marks remain, including the barrier cycle itself, owned stores are queued and drain after the marked entries. Direct writes resume once they have drained.
- R9: A barrier with `bar_kind` 2'b01 (load ordering) leaves the buffer unchanged, and direct writes remain possible.
- R10: After reset `sb_empty` is high and `cw_valid`, `rinv_valid`, `st_stall` and `ld_stall` are low. `sb_empty` is high exactly when no entry is held.
- R11: An owned store to a line that still has a buffered entry is queued rather than written directly, and it can be forwarded to loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | WADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_owned | input | 1 | Target line is held writable by the cache |
| st_stall | output | 1 | Store not accepted this cycle |
| ld_valid | input | 1 | Load request |
| ld_addr | input | WADDR_W | Load word address |
| ld_be | input | DATA_W/8 | Requested bytes |
| ld_fwd_hit | output | 1 | Load served from the buffer |
| ld_fwd_data | output | DATA_W | Forwarded data |
| ld_stall | output | 1 | Load must wait for a partial match to drain |
| bar_valid | input | 1 | Barrier strobe |
| bar_kind | input | 2 | 01 load-ordering, 10 store-ordering, 11 full |
| rinv_valid | output | 1 | Read-for-ownership request |
| rinv_line | output | WADDR_W-LINE_LG | Line for the request |
| own_valid | input | 1 | Ownership granted |
| own_line | input | WADDR_W-LINE_LG | Line now writable |
| cw_valid | output | 1 | Cache write request |
| cw_addr | output | WADDR_W | Cache write word address |
| cw_data | output | DATA_W | Cache write data |
| cw_be | output | DATA_W/8 | Cache write byte enables |
| cw_ready | input | 1 | Cache accepts the write |
| sb_empty | output | 1 | No entry held |

## Verification
The bench builds the block with four entries, an 8-bit word address, four words per line and 32-bit data. Four stores therefore fill the buffer and make the full stall reachable quickly. The small line size lets same-line and other-line cases be placed deliberately. The bench sweeps all 225 pairs of nonzero store and load byte enables, deriving hit or stall from their arithmetic coverage, and it tries every barrier kind against a pending unowned entry. Drain order is checked across mixed owned and unowned entries whose grants arrive in reverse order.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        SB_EMPTY  = 2'd0,
        SB_OPEN   = 2'd1,
        SB_FENCED = 2'd2
    } sb_state_e;

    localparam logic [1:0] BAR_LOAD  = 2'b01;
    localparam logic [1:0] BAR_STORE = 2'b10;
    localparam logic [1:0] BAR_BOTH  = 2'b11;

    // Bit 1 of the barrier kind selects store ordering.
    function automatic logic bar_orders_stores(input logic [1:0] kind);
        return kind[1];
    endfunction

endpackage

// File: rtl/sb_entry_array.sv
module sb_entry_array #(
    parameter int DEPTH   = 8,
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32,
    parameter int LINE_LG = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int BE_W   = DATA_W / 8,
    localparam int LINE_W = WADDR_W - LINE_LG
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [PTR_W-1:0]                push_idx,
    input  logic [WADDR_W-1:0]              push_addr,
    input  logic [DATA_W-1:0]               push_data,
    input  logic [BE_W-1:0]                 push_be,
    input  logic                            push_owned,
    input  logic                            pop,
    input  logic [PTR_W-1:0]                pop_idx,
    input  logic                            grant_valid,
    input  logic [LINE_W-1:0]               grant_line,
    output logic [DEPTH-1:0]                ent_valid,
    output logic [DEPTH-1:0]                ent_owned,
    output logic [DEPTH-1:0][WADDR_W-1:0]   ent_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]    ent_data,
    output logic [DEPTH-1:0][BE_W-1:0]      ent_be
);

    logic own_on_entry;
    assign own_on_entry = push_owned ||
                          (grant_valid && (push_addr[WADDR_W-1:LINE_LG] == grant_line));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            ent_owned <= '0;
            ent_addr  <= '0;
            ent_data  <= '0;
            ent_be    <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && (push_idx == PTR_W'(i))) begin
                    ent_valid[i] <= 1'b1;
                    ent_owned[i] <= own_on_entry;
                    ent_addr[i]  <= push_addr;
                    ent_data[i]  <= push_data;
                    ent_be[i]    <= push_be;
                end else begin
                    if (pop && (pop_idx == PTR_W'(i)))
                        ent_valid[i] <= 1'b0;
                    if (grant_valid && ent_valid[i] &&
                        (ent_addr[i][WADDR_W-1:LINE_LG] == grant_line))
                        ent_owned[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sb_fwd_search.sv
module sb_fwd_search #(
    parameter int DEPTH   = 8,
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32,
    parameter int LINE_LG = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int BE_W   = DATA_W / 8
) (
    input  logic [DEPTH-1:0]                ent_valid,
    input  logic [DEPTH-1:0][WADDR_W-1:0]   ent_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]    ent_data,
    input  logic [DEPTH-1:0][BE_W-1:0]      ent_be,
    input  logic [PTR_W-1:0]                head_idx,
    input  logic                            ld_valid,
    input  logic [WADDR_W-1:0]              ld_addr,
    input  logic [BE_W-1:0]                 ld_be,
    input  logic [WADDR_W-1:0]              st_addr,
    output logic                            fwd_hit,
    output logic                            fwd_stall,
    output logic [DATA_W-1:0]               fwd_data,
    output logic                            line_busy
);

    logic [DEPTH-1:0] word_hit;
    logic [DEPTH-1:0] line_hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign word_hit[g] = ent_valid[g] && (ent_addr[g] == ld_addr);
        assign line_hit[g] = ent_valid[g] &&
            (ent_addr[g][WADDR_W-1:LINE_LG] == st_addr[WADDR_W-1:LINE_LG]);
    end

    logic             found;
    logic [PTR_W-1:0] youngest;
    logic [PTR_W-1:0] idx;
    logic             covered;

    // Walk from oldest to youngest; the last match seen is the youngest.
    always_comb begin
        found    = 1'b0;
        youngest = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_idx + PTR_W'(k);
            if (word_hit[idx]) begin
                found    = 1'b1;
                youngest = idx;
            end
        end
    end

    assign covered   = ((ent_be[youngest] & ld_be) == ld_be);
    assign fwd_hit   = ld_valid && found && covered;
    assign fwd_stall = ld_valid && found && !covered;
    assign fwd_data  = ent_data[youngest];
    assign line_busy = |line_hit;

endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             st_owned,
    input  logic             line_busy,
    input  logic             cw_ready,
    input  logic             bar_valid,
    input  logic [1:0]       bar_kind,
    input  logic             head_ready,
    output logic             direct_take,
    output logic             push,
    output logic             pop,
    output logic             st_stall,
    output logic [PTR_W-1:0] head_idx,
    output logic [PTR_W-1:0] tail_idx,
    output logic [CNT_W-1:0] occ_cnt,
    output logic [CNT_W-1:0] mark_cnt,
    output logic             sb_empty
);

    sb_state_e  state, state_n;
    logic       is_empty, is_fenced;
    logic       bar_st, fence_now, full;
    logic [CNT_W-1:0] cnt_after, mark_after, cnt_next, mark_next;

    // Output decode from the state.
    always_comb begin
        unique case (state)
            SB_EMPTY:  begin is_empty = 1'b1; is_fenced = 1'b0; end
            SB_OPEN:   begin is_empty = 1'b0; is_fenced = 1'b0; end
            SB_FENCED: begin is_empty = 1'b0; is_fenced = 1'b1; end
            default:   begin is_empty = 1'b1; is_fenced = 1'b0; end
        endcase
    end

    assign sb_empty    = is_empty;
    assign bar_st      = bar_valid && bar_orders_stores(bar_kind);
    assign fence_now   = is_fenced || (bar_st && !is_empty);
    assign full        = (occ_cnt == CNT_W'(DEPTH));
    assign direct_take = st_valid && st_owned && !line_busy && !fence_now && cw_ready;
    assign push        = st_valid && !direct_take && !full;
    assign st_stall    = st_valid && !direct_take && full;
    assign pop         = head_ready && cw_ready && !direct_take;

    assign cnt_after  = occ_cnt - CNT_W'(pop);
    assign mark_after = mark_cnt - CNT_W'(pop && (mark_cnt != '0));
    assign cnt_next   = cnt_after + CNT_W'(push);
    // A barrier is older than a store of the same cycle.
    assign mark_next  = bar_st ? cnt_after : mark_after;

    // Next-state process.
    always_comb begin
        state_n = state;
        unique case (state)
            SB_EMPTY:  state_n = push ? SB_OPEN : SB_EMPTY;
            SB_OPEN: begin
                if (cnt_next == '0)        state_n = SB_EMPTY;
                else if (mark_next != '0)  state_n = SB_FENCED;
                else                       state_n = SB_OPEN;
            end
            SB_FENCED: begin
                if (cnt_next == '0)        state_n = SB_EMPTY;
                else if (mark_next == '0)  state_n = SB_OPEN;
                else                       state_n = SB_FENCED;
            end
            default:                       state_n = SB_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SB_EMPTY;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_idx <= '0;
            tail_idx <= '0;
            occ_cnt  <= '0;
            mark_cnt <= '0;
        end else begin
            head_idx <= head_idx + PTR_W'(pop);
            tail_idx <= tail_idx + PTR_W'(push);
            occ_cnt  <= cnt_next;
            mark_cnt <= mark_next;
        end
    end

endmodule

// File: rtl/store_buffer.sv
module store_buffer #(
    parameter int DEPTH   = 8,
    parameter int WADDR_W = 30,
    parameter int DATA_W  = 32,
    parameter int LINE_LG = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         st_valid,
    input  logic [WADDR_W-1:0]           st_addr,
    input  logic [DATA_W-1:0]            st_data,
    input  logic [DATA_W/8-1:0]          st_be,
    input  logic                         st_owned,
    output logic                         st_stall,
    input  logic                         ld_valid,
    input  logic [WADDR_W-1:0]           ld_addr,
    input  logic [DATA_W/8-1:0]          ld_be,
    output logic                         ld_fwd_hit,
    output logic [DATA_W-1:0]            ld_fwd_data,
    output logic                         ld_stall,
    input  logic                         bar_valid,
    input  logic [1:0]                   bar_kind,
    output logic                         rinv_valid,
    output logic [WADDR_W-LINE_LG-1:0]   rinv_line,
    input  logic                         own_valid,
    input  logic [WADDR_W-LINE_LG-1:0]   own_line,
    output logic                         cw_valid,
    output logic [WADDR_W-1:0]           cw_addr,
    output logic [DATA_W-1:0]            cw_data,
    output logic [DATA_W/8-1:0]          cw_be,
    input  logic                         cw_ready,
    output logic                         sb_empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BE_W  = DATA_W / 8;

    logic [DEPTH-1:0]              ent_valid, ent_owned;
    logic [DEPTH-1:0][WADDR_W-1:0] ent_addr;
    logic [DEPTH-1:0][DATA_W-1:0]  ent_data;
    logic [DEPTH-1:0][BE_W-1:0]    ent_be;

    logic             direct_take, push, pop, line_busy, head_ready;
    logic [PTR_W-1:0] head_idx, tail_idx;
    logic [CNT_W-1:0] occ_cnt, mark_cnt;

    assign head_ready = ent_valid[head_idx] && ent_owned[head_idx];

    sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_valid    (st_valid),
        .st_owned    (st_owned),
        .line_busy   (line_busy),
        .cw_ready    (cw_ready),
        .bar_valid   (bar_valid),
        .bar_kind    (bar_kind),
        .head_ready  (head_ready),
        .direct_take (direct_take),
        .push        (push),
        .pop         (pop),
        .st_stall    (st_stall),
        .head_idx    (head_idx),
        .tail_idx    (tail_idx),
        .occ_cnt     (occ_cnt),
        .mark_cnt    (mark_cnt),
        .sb_empty    (sb_empty)
    );

    sb_entry_array #(
        .DEPTH(DEPTH), .WADDR_W(WADDR_W), .DATA_W(DATA_W), .LINE_LG(LINE_LG)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_idx    (tail_idx),
        .push_addr   (st_addr),
        .push_data   (st_data),
        .push_be     (st_be),
        .push_owned  (st_owned),
        .pop         (pop),
        .pop_idx     (head_idx),
        .grant_valid (own_valid),
        .grant_line  (own_line),
        .ent_valid   (ent_valid),
        .ent_owned   (ent_owned),
        .ent_addr    (ent_addr),
        .ent_data    (ent_data),
        .ent_be      (ent_be)
    );

    sb_fwd_search #(
        .DEPTH(DEPTH), .WADDR_W(WADDR_W), .DATA_W(DATA_W), .LINE_LG(LINE_LG)
    ) u_search (
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_be    (ent_be),
        .head_idx  (head_idx),
        .ld_valid  (ld_valid),
        .ld_addr   (ld_addr),
        .ld_be     (ld_be),
        .st_addr   (st_addr),
        .fwd_hit   (ld_fwd_hit),
        .fwd_stall (ld_stall),
        .fwd_data  (ld_fwd_data),
        .line_busy (line_busy)
    );

    assign cw_valid   = direct_take || head_ready;
    assign cw_addr    = direct_take ? st_addr : ent_addr[head_idx];
    assign cw_data    = direct_take ? st_data : ent_data[head_idx];
    assign cw_be      = direct_take ? st_be   : ent_be[head_idx];
    assign rinv_valid = push && !st_owned;
    assign rinv_line  = st_addr[WADDR_W-1:LINE_LG];

endmodule

// File: rtl/store_buffer_chk.sv
module store_buffer_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_valid,
    input logic             st_stall,
    input logic             rinv_valid,
    input logic             ld_valid,
    input logic             ld_fwd_hit,
    input logic             ld_stall,
    input logic             bar_valid,
    input logic [1:0]       bar_kind,
    input logic             cw_ready,
    input logic             sb_empty,
    input logic [CNT_W-1:0] occ_cnt,
    input logic [CNT_W-1:0] mark_cnt
);

    assert_rinv_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rinv_valid |=> !sb_empty);

    assert_fwd_needs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fwd_hit || ld_stall) |-> ld_valid);

    assert_hit_or_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_fwd_hit && ld_stall));

    assert_stall_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (occ_cnt == CNT_W'(DEPTH)));

    assert_no_rinv_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> !rinv_valid);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CNT_W'(DEPTH));

    assert_marks_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mark_cnt <= occ_cnt);

    assert_fence_queues_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mark_cnt != '0 && st_valid && !st_stall && !cw_ready)
            |=> occ_cnt == $past(occ_cnt) + CNT_W'(1));

    assert_load_bar_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bar_valid && bar_kind == 2'b01 && mark_cnt == '0) |=> mark_cnt == '0);

    assert_empty_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sb_empty |-> (occ_cnt == '0));

endmodule

bind store_buffer store_buffer_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_stall   (st_stall),
    .rinv_valid (rinv_valid),
    .ld_valid   (ld_valid),
    .ld_fwd_hit (ld_fwd_hit),
    .ld_stall   (ld_stall),
    .bar_valid  (bar_valid),
    .bar_kind   (bar_kind),
    .cw_ready   (cw_ready),
    .sb_empty   (sb_empty),
    .occ_cnt    (occ_cnt),
    .mark_cnt   (mark_cnt)
);

// File: tb/store_buffer_tb_top.sv
module store_buffer_tb_top;

    localparam int DEPTH   = 4;
    localparam int WADDR_W = 8;
    localparam int DATA_W  = 32;
    localparam int LINE_LG = 2;
    localparam int BE_W    = DATA_W / 8;
    localparam int LINE_W  = WADDR_W - LINE_LG;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic st_valid, st_owned, st_stall;
    logic [WADDR_W-1:0] st_addr, ld_addr, cw_addr;
    logic [DATA_W-1:0]  st_data, ld_fwd_data, cw_data;
    logic [BE_W-1:0]    st_be, ld_be, cw_be;
    logic ld_valid, ld_fwd_hit, ld_stall;
    logic bar_valid;
    logic [1:0] bar_kind;
    logic rinv_valid, own_valid, cw_valid, cw_ready, sb_empty;
    logic [LINE_W-1:0] rinv_line, own_line;

    store_buffer #(.DEPTH(DEPTH), .WADDR_W(WADDR_W), .DATA_W(DATA_W), .LINE_LG(LINE_LG)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_owned(st_owned), .st_stall(st_stall),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_be(ld_be),
        .ld_fwd_hit(ld_fwd_hit), .ld_fwd_data(ld_fwd_data), .ld_stall(ld_stall),
        .bar_valid(bar_valid), .bar_kind(bar_kind),
        .rinv_valid(rinv_valid), .rinv_line(rinv_line),
        .own_valid(own_valid), .own_line(own_line),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_data(cw_data), .cw_be(cw_be),
        .cw_ready(cw_ready), .sb_empty(sb_empty)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  finished = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic next();
        @(negedge clk);
        st_valid  = 1'b0;
        ld_valid  = 1'b0;
        bar_valid = 1'b0;
        own_valid = 1'b0;
    endtask

    task automatic put(input logic [WADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic [BE_W-1:0] be, input logic owned);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_owned = owned;
    endtask

    task automatic load(input logic [WADDR_W-1:0] a, input logic [BE_W-1:0] be);
        ld_valid = 1'b1; ld_addr = a; ld_be = be;
    endtask

    task automatic expect_cw(input string tag, input logic [WADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d);
        next(); #1;
        check({tag, " cw_valid"}, cw_valid, 1'b1);
        check({tag, " cw_addr"},  cw_addr, a);
        check({tag, " cw_data"},  cw_data, d);
    endtask

    task automatic flush(input logic [LINE_W-1:0] line);
        next(); own_valid = 1'b1; own_line = line; cw_ready = 1'b1;
        for (int n = 0; n < 12; n++) begin
            next(); #1;
            if (sb_empty) break;
        end
        cw_ready = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R10 act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        st_valid = 0; st_addr = '0; st_data = '0; st_be = '0; st_owned = 0;
        ld_valid = 0; ld_addr = '0; ld_be = '0;
        bar_valid = 0; bar_kind = 2'b00; own_valid = 0; own_line = '0; cw_ready = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        check("R10 empty",  sb_empty, 1'b1);
        check("R10 cw",     cw_valid, 1'b0);
        check("R10 rinv",   rinv_valid, 1'b0);
        check("R10 ststall", st_stall, 1'b0);
        check("R10 ldstall", ld_stall, 1'b0);

        // R1 unowned store
        next(); put(8'h10, 32'hAAAA_0001, 4'hF, 1'b0); #1;
        check("R1 rinv",      rinv_valid, 1'b1);
        check("R1 rinv_line", rinv_line, 6'h04);
        check("R1 no stall",  st_stall, 1'b0);
        check("R6 unowned not written", cw_valid, 1'b0);
        next(); load(8'h10, 4'hF); #1;
        check("R10 not empty", sb_empty, 1'b0);
        check("R2 hit",  ld_fwd_hit, 1'b1);
        check("R2 data", ld_fwd_data, 32'hAAAA_0001);
        next(); load(8'h10, 4'h3); #1;
        check("R2 subset hit", ld_fwd_hit, 1'b1);

        // R7 owned store bypasses unowned entry on another line
        next(); cw_ready = 1'b1; put(8'h40, 32'hBBBB_0002, 4'hF, 1'b1); #1;
        check("R7 direct valid", cw_valid, 1'b1);
        check("R7 direct addr",  cw_addr, 8'h40);
        check("R7 direct data",  cw_data, 32'hBBBB_0002);
        check("R7 no rinv",      rinv_valid, 1'b0);
        next(); load(8'h40, 4'hF); #1;
        check("R3 miss hit",   ld_fwd_hit, 1'b0);
        check("R3 miss stall", ld_stall, 1'b0);

        // R11 owned store to busy line is queued
        next(); put(8'h11, 32'hDDDD_0003, 4'hF, 1'b1); #1;
        check("R11 queued not written", cw_valid, 1'b0);
        cw_ready = 1'b0;
        next(); load(8'h11, 4'hF); #1;
        check("R11 forwarded", ld_fwd_data, 32'hDDDD_0003);
        check("R11 hit", ld_fwd_hit, 1'b1);

        // R2 youngest of two
        next(); put(8'h10, 32'hCCCC_0004, 4'hF, 1'b0); #1;
        next(); load(8'h10, 4'hF); #1;
        check("R2 youngest", ld_fwd_data, 32'hCCCC_0004);

        // R5 full
        next(); put(8'h20, 32'hEEEE_0005, 4'hF, 1'b0); #1;
        check("R5 fourth accepted", st_stall, 1'b0);
        next(); put(8'h24, 32'hFFFF_0006, 4'hF, 1'b0); #1;
        check("R5 stall", st_stall, 1'b1);
        check("R5 no rinv", rinv_valid, 1'b0);
        next(); load(8'h24, 4'hF); #1;
        check("R5 not entered", ld_fwd_hit, 1'b0);

        // R6 order: grant later line first
        next(); own_valid = 1'b1; own_line = 6'h08; cw_ready = 1'b1; #1;
        next(); #1;
        check("R6 head unowned blocks", cw_valid, 1'b0);
        next(); own_valid = 1'b1; own_line = 6'h04; #1;
        check("R6 grant cycle", cw_valid, 1'b0);
        expect_cw("R6 first",  8'h10, 32'hAAAA_0001);
        expect_cw("R6 second", 8'h11, 32'hDDDD_0003);
        expect_cw("R6 third",  8'h10, 32'hCCCC_0004);
        expect_cw("R6 fourth", 8'h20, 32'hEEEE_0005);
        next(); #1;
        check("R10 drained", sb_empty, 1'b1);
        check("R6 idle", cw_valid, 1'b0);
        cw_ready = 1'b0;

        // R8 store barrier keeps order
        next(); put(8'h30, 32'h1234_0007, 4'hF, 1'b0);
        next(); bar_valid = 1'b1; bar_kind = 2'b10;
        next(); cw_ready = 1'b1; put(8'h50, 32'h1234_0008, 4'hF, 1'b1); #1;
        check("R8 fenced no direct", cw_valid, 1'b0);
        next(); load(8'h50, 4'hF); #1;
        check("R8 queued fwd", ld_fwd_hit, 1'b1);
        next(); own_valid = 1'b1; own_line = 6'h0C;
        expect_cw("R8 marked first", 8'h30, 32'h1234_0007);
        expect_cw("R8 later second", 8'h50, 32'h1234_0008);
        next(); put(8'h50, 32'h1234_0009, 4'hF, 1'b1); #1;
        check("R8 direct resumes", cw_valid, 1'b1);
        check("R8 direct data", cw_data, 32'h1234_0009);
        cw_ready = 1'b0;

        // R8 / R9 sweep over barrier kinds
        for (int k = 1; k < 4; k++) begin
            next(); put(8'h30, 32'h5555_0000, 4'hF, 1'b0);
            next(); bar_valid = 1'b1; bar_kind = 2'(k);
            next(); cw_ready = 1'b1; put(8'h50, 32'h6666_0000, 4'hF, 1'b1); #1;
            if (k == 1) check("R9 load barrier inert", cw_valid, 1'b1);
            else        check("R8 barrier blocks", cw_valid, 1'b0);
            cw_ready = 1'b0;
            flush(6'h0C);
            check("R10 empty after flush", sb_empty, 1'b1);
        end

        // R2 / R4 byte-enable sweep
        for (int sb = 1; sb < 16; sb++) begin
            for (int lb = 1; lb < 16; lb++) begin
                logic exp_hit;
                exp_hit = ((sb & lb) == lb);
                next(); put(8'h08, 32'hA1B2_C3D4, 4'(sb), 1'b0);
                next(); load(8'h08, 4'(lb)); #1;
                check(exp_hit ? "R2 cover hit" : "R4 partial hit", ld_fwd_hit, exp_hit);
                check("R4 partial stall", ld_stall, !exp_hit);
                if (exp_hit) check("R2 sweep data", ld_fwd_data, 32'hA1B2_C3D4);
                flush(6'h02);
                next(); load(8'h08, 4'(lb)); #1;
                check("R4 released", ld_stall, 1'b0);
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule